// File: doc/BRIEF.md
# Ring-Qualified Seven-Way TLB Lookup

This block searches a seven-way translation buffer for one virtual address each cycle. Ways 0 to 3 hold refillable 4 KB pages. Way 4 has a page size chosen by a two-bit field of a size-configuration register. Ways 5 and 6 are either fixed, with 128 MB and 256 MB pages loaded with preset mappings at reset, or tunable, with one size bit each. For every way the address gives an entry index and a masked tag. The stored tag and the stored ASID of that entry are then checked. An entry counts as a hit only if its ASID is nonzero and is found in one of the four byte slots of a ring-ASID register. The slot number is the privilege ring of the hit.

A lookup is requested with `lk_valid`. One cycle later the block reports the result with `rsp_valid`: hit, miss or multi-hit status, a fault code that depends on whether the lookup came from the instruction side or the data side, and, on a single hit, the way, entry index, ring, translated physical address and attribute. A write port installs an entry in a chosen way, taking the index and tag from a virtual address and the physical page, attribute and ring selection from a page-table entry. Entries loaded at reset as immutable refuse all writes.

Top module: `tlb_ring_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0 and all response fields are 0. The ring-ASID register holds 0x04030201, meaning ASID 1 is ring 0, ASID 2 is ring 1, ASID 3 is ring 2 and ASID 4 is ring 3. All size fields are 0 and ways 0 to 4 hold only ASID 0 entries.
- R2: With fixed ways 5/6 (the default), reset loads four immutable entries, all with ASID 1. Way 5 index 0 maps 0xD0000000 to 0x00000000 with attribute 7, and way 5 index 1 maps 0xD8000000 to 0x00000000 with attribute 3. Way 6 index 0 maps 0xE0000000 to 0xF0000000 with attribute 7, and way 6 index 1 maps 0xF0000000 to 0xF0000000 with attribute 3.
- R3: Ways 0 to 3 use the tag mask 0xFFFFF000. Their entry index is address bits [13:12], or bits [14:12] when those ways are built with 8 entries.
- R4: Way 4 takes its size field f from bits [17:16] of the configuration word written with `cfg_we`. Its tag mask is 0xFFF00000 shifted left by 2f, and its index is the 2 address bits starting at bit 20+2f.
- R5: In fixed mode, way 5 uses mask 0xF8000000 with index bit 27, and way 6 uses mask 0xF0000000 with index bit 28. In tunable mode, the way 5 size bit is configuration bit 20 and the way 6 size bit is configuration bit 24.
- R6: A way hits when the entry's tag equals the address ANDed with the way mask, the entry's ASID is nonzero, and that ASID equals a byte of the ring-ASID register. `rsp_ring` is the lowest byte slot that matches. Status codes are 0 for hit, 1 for miss and 2 for multi-hit.
- R7: When two or more ways hit, the status is 2 and way, index, ring, paddr and attr are all 0.
- R8: When no way hits, the status is 1 and way, index, ring, paddr and attr are all 0.
- R9: The fault code is 0 on a hit. On the instruction side (`lk_data_side`=0) a miss gives 16 and a multi-hit gives 17. On the data side a miss gives 24 and a multi-hit gives 25.
- R10: A write to the ring-ASID register stores the written word with bits [7:0] forced to 0x01.
- R11: An entry write stores tag = vaddr AND mask, physical page = PTE AND mask and attribute = PTE[3:0]. Its ASID is the ring-ASID byte selected by PTE[5:4], read before any ring write in the same cycle. A write to way 7 does nothing.
- R12: Writes to immutable entries leave them unchanged.
- R13: `rsp_valid` is high exactly one cycle after `lk_valid`. Response fields change only in the cycle after a request.
- R14: On a hit, `rsp_paddr` is the stored physical page ORed with the address bits outside the way mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load size fields from cfg_wdata |
| cfg_wdata | input | 32 | Size configuration word |
| ring_we | input | 1 | Load ring-ASID register |
| ring_wdata | input | 32 | Ring-ASID word, low byte forced to 0x01 |
| ent_we | input | 1 | Entry write strobe |
| ent_way | input | 3 | Way to write |
| ent_vaddr | input | 32 | Virtual address giving index and tag |
| ent_pte | input | 32 | Page-table entry: page, ring select [5:4], attribute [3:0] |
| lk_valid | input | 1 | Lookup request |
| lk_data_side | input | 1 | 1 = data-side lookup, 0 = instruction-side |
| lk_vaddr | input | 32 | Lookup address |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 multi-hit |
| rsp_fault | output | 6 | Fault code, 0 on a hit |
| rsp_way | output | 3 | Hitting way |
| rsp_index | output | 3 | Hitting entry index |
| rsp_ring | output | 2 | Ring of the hitting ASID |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_attr | output | 4 | Attribute of the hitting entry |

## Verification
Lookups are aimed at the preset entries of ways 5 and 6 and at entries installed in refill ways under different index bits. These separate a correct index or mask choice from one that picks the wrong entry or leaks offset bits into the physical address. Way 4 is searched under two size settings with the same address, so a size field taken from the wrong bits turns a hit into a miss. An address covered by both a refill entry and a preset entry separates a multi-hit from a first-hit-wins design. Rewriting the ring register after entries were installed shows whether ring qualification uses the live register, whether the low byte is forced, and whether a write to an immutable entry leaks through.

// File: rtl/tlb_ring_pkg.sv
package tlb_ring_pkg;

  parameter int VA_W      = 32;
  parameter int NUM_WAYS  = 7;
  parameter int WAY_W     = 3;
  parameter int IDX_W     = 3;
  parameter int ASID_W    = 8;
  parameter int ATTR_W    = 4;
  parameter int RING_W    = 2;
  parameter int NUM_RINGS = 4;
  parameter int FAULT_W   = 6;
  parameter int SZ4_W     = 2;

  localparam int RING_REG_W = NUM_RINGS * ASID_W;

  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_MISS  = 2'd1,
    ST_MULTI = 2'd2
  } lk_status_e;

  localparam logic [FAULT_W-1:0] FC_I_MISS  = 6'd16;
  localparam logic [FAULT_W-1:0] FC_I_MULTI = 6'd17;
  localparam logic [FAULT_W-1:0] FC_D_MISS  = 6'd24;
  localparam logic [FAULT_W-1:0] FC_D_MULTI = 6'd25;

  localparam logic [RING_REG_W-1:0] RING_RESET = 32'h0403_0201;
  localparam logic [ASID_W-1:0]     RING0_ASID = 8'h01;

  typedef struct packed {
    logic [VA_W-1:0]   tag;
    logic [VA_W-1:0]   ppage;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
    logic              locked;
  } tlb_ent_t;

  typedef struct packed {
    lk_status_e         status;
    logic [FAULT_W-1:0] fault;
    logic [WAY_W-1:0]   way;
    logic [IDX_W-1:0]   idx;
    logic [RING_W-1:0]  ring;
    logic [VA_W-1:0]    paddr;
    logic [ATTR_W-1:0]  attr;
  } lk_rsp_t;

  // Reset content of one entry: fixed ways 5/6 get locked preset pages,
  // tunable way 6 gets identity 512 MB pages, everything else is empty.
  function automatic tlb_ent_t preset_entry(int way, int ei, bit tunable);
    tlb_ent_t e;
    e = '0;
    if (!tunable && way == 5 && ei < 2) begin
      e.tag    = (ei == 0) ? 32'hD000_0000 : 32'hD800_0000;
      e.ppage  = '0;
      e.asid   = 8'h01;
      e.attr   = (ei == 0) ? 4'd7 : 4'd3;
      e.locked = 1'b1;
    end else if (!tunable && way == 6 && ei < 2) begin
      e.tag    = (ei == 0) ? 32'hE000_0000 : 32'hF000_0000;
      e.ppage  = 32'hF000_0000;
      e.asid   = 8'h01;
      e.attr   = (ei == 0) ? 4'd7 : 4'd3;
      e.locked = 1'b1;
    end else if (tunable && way == 6) begin
      e.tag    = VA_W'(ei) << 29;
      e.ppage  = VA_W'(ei) << 29;
      e.asid   = 8'h01;
      e.attr   = 4'd3;
    end
    return e;
  endfunction

endpackage

// File: rtl/tlb_way_geom.sv
module tlb_way_geom
  import tlb_ring_pkg::*;
#(
  parameter int WAY_ID  = 0,
  parameter int TUNABLE = 0,
  parameter int IW      = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [SZ4_W-1:0] sz4,
  input  logic             sz5,
  input  logic             sz6,
  output logic [VA_W-1:0]  mask,
  output logic [IW-1:0]    idx
);

  localparam logic [VA_W-1:0] M_4K   = {VA_W{1'b1}} << 12;
  localparam logic [VA_W-1:0] M_1M   = {VA_W{1'b1}} << 20;
  localparam logic [VA_W-1:0] M_128M = {VA_W{1'b1}} << 27;
  localparam logic [VA_W-1:0] M_256M = {VA_W{1'b1}} << 28;

  generate
    if (WAY_ID < 4) begin : g_refill
      assign mask = M_4K;
      assign idx  = va[12 +: IW];
    end else if (WAY_ID == 4) begin : g_way4
      logic [4:0] base;
      assign base = 5'd20 + {2'b00, sz4, 1'b0};
      assign mask = M_1M << {sz4, 1'b0};
      assign idx  = va[base +: IW];
    end else if (WAY_ID == 5 && TUNABLE != 0) begin : g_way5_tun
      logic [4:0] base;
      assign base = 5'd27 + {4'b0000, sz5};
      assign mask = M_128M << sz5;
      assign idx  = va[base +: IW];
    end else if (WAY_ID == 5) begin : g_way5_fix
      assign mask = M_128M;
      assign idx  = va[27 +: IW];
    end else if (TUNABLE != 0) begin : g_way6_tun
      logic [4:0] base;
      assign base = sz6 ? 5'd28 : 5'd29;
      assign mask = sz6 ? M_256M : (M_256M << 1);
      assign idx  = va[base +: IW];
    end else begin : g_way6_fix
      assign mask = M_256M;
      assign idx  = va[28 +: IW];
    end
  endgenerate

endmodule

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
  import tlb_ring_pkg::*;
#(
  parameter int WAY_ID  = 0,
  parameter int NENT    = 4,
  parameter int TUNABLE = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SZ4_W-1:0]      sz4,
  input  logic                  sz5,
  input  logic                  sz6,
  input  logic [RING_REG_W-1:0] ring_asid,
  input  logic                  wr_en,
  input  logic [VA_W-1:0]       wr_va,
  input  logic [VA_W-1:0]       wr_pte,
  input  logic [VA_W-1:0]       lk_va,
  output logic                  hit,
  output logic [RING_W-1:0]     ring,
  output logic [IDX_W-1:0]      idx,
  output logic [VA_W-1:0]       paddr,
  output logic [ATTR_W-1:0]     attr
);

  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;

  tlb_ent_t ent_q [NENT];
  tlb_ent_t ent_d [NENT];

  logic [VA_W-1:0] wr_mask, lk_mask;
  logic [IW-1:0]   wr_idx, lk_idx;

  tlb_way_geom #(.WAY_ID(WAY_ID), .TUNABLE(TUNABLE), .IW(IW)) u_geom_wr (
    .va(wr_va), .sz4(sz4), .sz5(sz5), .sz6(sz6), .mask(wr_mask), .idx(wr_idx)
  );

  tlb_way_geom #(.WAY_ID(WAY_ID), .TUNABLE(TUNABLE), .IW(IW)) u_geom_lk (
    .va(lk_va), .sz4(sz4), .sz5(sz5), .sz6(sz6), .mask(lk_mask), .idx(lk_idx)
  );

  // Entry update: locked entries keep their content.
  always_comb begin
    ent_d = ent_q;
    if (!ent_q[wr_idx].locked) begin
      ent_d[wr_idx].tag   = wr_va & wr_mask;
      ent_d[wr_idx].ppage = wr_pte & wr_mask;
      ent_d[wr_idx].asid  = ring_asid[{wr_pte[5:4], 3'b000} +: ASID_W];
      ent_d[wr_idx].attr  = wr_pte[ATTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        ent_q[e] <= preset_entry(WAY_ID, e, TUNABLE != 0);
      end
    end else if (wr_en) begin
      ent_q <= ent_d;
    end
  end

  // Lookup: tag compare, nonzero ASID, then ring slot search.
  tlb_ent_t sel;
  logic     tag_ok;
  logic     ring_found;

  always_comb begin
    sel        = ent_q[lk_idx];
    tag_ok     = (sel.tag == (lk_va & lk_mask)) && (sel.asid != '0);
    ring_found = 1'b0;
    ring       = '0;
    for (int r = NUM_RINGS - 1; r >= 0; r--) begin
      if (ring_asid[r*ASID_W +: ASID_W] == sel.asid) begin
        ring_found = 1'b1;
        ring       = RING_W'(r);
      end
    end
  end

  assign hit   = tag_ok && ring_found;
  assign idx   = IDX_W'(lk_idx);
  assign paddr = sel.ppage | (lk_va & ~lk_mask);
  assign attr  = sel.attr;

endmodule

// File: rtl/tlb_hit_merge.sv
module tlb_hit_merge
  import tlb_ring_pkg::*;
(
  input  logic [NUM_WAYS-1:0]             hit,
  input  logic [NUM_WAYS-1:0][RING_W-1:0] ring,
  input  logic [NUM_WAYS-1:0][IDX_W-1:0]  idx,
  input  logic [NUM_WAYS-1:0][VA_W-1:0]   paddr,
  input  logic [NUM_WAYS-1:0][ATTR_W-1:0] attr,
  input  logic                            data_side,
  output lk_rsp_t                         rsp
);

  logic [WAY_W:0] n_hits;
  lk_rsp_t        sel;

  // OR-reduce the per-way results; only meaningful with exactly one hit.
  always_comb begin
    n_hits = '0;
    sel    = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit[w]) begin
        n_hits    = n_hits + 1'b1;
        sel.way   = sel.way | WAY_W'(w);
        sel.idx   = sel.idx | idx[w];
        sel.ring  = sel.ring | ring[w];
        sel.paddr = sel.paddr | paddr[w];
        sel.attr  = sel.attr | attr[w];
      end
    end
  end

  always_comb begin
    rsp = '0;
    if (n_hits == '0) begin
      rsp.status = ST_MISS;
      rsp.fault  = data_side ? FC_D_MISS : FC_I_MISS;
    end else if (n_hits == 1) begin
      rsp        = sel;
      rsp.status = ST_HIT;
      rsp.fault  = '0;
    end else begin
      rsp.status = ST_MULTI;
      rsp.fault  = data_side ? FC_D_MULTI : FC_I_MULTI;
    end
  end

endmodule

// File: rtl/tlb_ring_lookup.sv
module tlb_ring_lookup
  import tlb_ring_pkg::*;
#(
  parameter int REFILL_ENT  = 4,
  parameter int TUNABLE_W56 = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [31:0]           cfg_wdata,
  input  logic                  ring_we,
  input  logic [31:0]           ring_wdata,
  input  logic                  ent_we,
  input  logic [2:0]            ent_way,
  input  logic [31:0]           ent_vaddr,
  input  logic [31:0]           ent_pte,
  input  logic                  lk_valid,
  input  logic                  lk_data_side,
  input  logic [31:0]           lk_vaddr,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_status,
  output logic [5:0]            rsp_fault,
  output logic [2:0]            rsp_way,
  output logic [2:0]            rsp_index,
  output logic [1:0]            rsp_ring,
  output logic [31:0]           rsp_paddr,
  output logic [3:0]            rsp_attr
);

  localparam int W4_ENT = 4;
  localparam int W5_ENT = (TUNABLE_W56 != 0) ? 4 : 2;
  localparam int W6_ENT = (TUNABLE_W56 != 0) ? 8 : 2;
  localparam int SZ4_LSB = 16;
  localparam int SZ5_BIT = 20;
  localparam int SZ6_BIT = 24;

  // Size configuration fields
  logic [SZ4_W-1:0] sz4_q, sz4_d;
  logic             sz5_q, sz5_d;
  logic             sz6_q, sz6_d;

  always_comb begin
    sz4_d = cfg_wdata[SZ4_LSB +: SZ4_W];
    sz5_d = cfg_wdata[SZ5_BIT];
    sz6_d = cfg_wdata[SZ6_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz4_q <= '0;
      sz5_q <= 1'b0;
      sz6_q <= 1'b0;
    end else if (cfg_we) begin
      sz4_q <= sz4_d;
      sz5_q <= sz5_d;
      sz6_q <= sz6_d;
    end
  end

  // Ring-ASID register: only the upper slots are stored, slot 0 is fixed.
  logic [RING_REG_W-ASID_W-1:0] ring_hi_q, ring_hi_d;
  logic [RING_REG_W-1:0]        ring_asid;

  assign ring_hi_d = ring_wdata[RING_REG_W-1:ASID_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_hi_q <= RING_RESET[RING_REG_W-1:ASID_W];
    end else if (ring_we) begin
      ring_hi_q <= ring_hi_d;
    end
  end

  assign ring_asid = {ring_hi_q, RING0_ASID};

  // Way banks
  logic [NUM_WAYS-1:0]             way_hit;
  logic [NUM_WAYS-1:0][RING_W-1:0] way_ring;
  logic [NUM_WAYS-1:0][IDX_W-1:0]  way_idx;
  logic [NUM_WAYS-1:0][VA_W-1:0]   way_paddr;
  logic [NUM_WAYS-1:0][ATTR_W-1:0] way_attr;

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      localparam int NENT = (w < 4) ? REFILL_ENT :
                            (w == 4) ? W4_ENT :
                            (w == 5) ? W5_ENT : W6_ENT;
      logic wr_sel;
      assign wr_sel = ent_we && (ent_way == WAY_W'(w));

      tlb_way_bank #(.WAY_ID(w), .NENT(NENT), .TUNABLE(TUNABLE_W56)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sz4      (sz4_q),
        .sz5      (sz5_q),
        .sz6      (sz6_q),
        .ring_asid(ring_asid),
        .wr_en    (wr_sel),
        .wr_va    (ent_vaddr),
        .wr_pte   (ent_pte),
        .lk_va    (lk_vaddr),
        .hit      (way_hit[w]),
        .ring     (way_ring[w]),
        .idx      (way_idx[w]),
        .paddr    (way_paddr[w]),
        .attr     (way_attr[w])
      );
    end
  endgenerate

  lk_rsp_t merged;

  tlb_hit_merge u_merge (
    .hit      (way_hit),
    .ring     (way_ring),
    .idx      (way_idx),
    .paddr    (way_paddr),
    .attr     (way_attr),
    .data_side(lk_data_side),
    .rsp      (merged)
  );

  // Response register
  lk_rsp_t rsp_q, rsp_d;
  logic    vld_q, vld_d;

  always_comb begin
    rsp_d = merged;
    vld_d = lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else if (lk_valid) begin
      rsp_q <= rsp_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_status = rsp_q.status;
  assign rsp_fault  = rsp_q.fault;
  assign rsp_way    = rsp_q.way;
  assign rsp_index  = rsp_q.idx;
  assign rsp_ring   = rsp_q.ring;
  assign rsp_paddr  = rsp_q.paddr;
  assign rsp_attr   = rsp_q.attr;

endmodule

// File: rtl/tlb_ring_lookup_chk.sv
module tlb_ring_lookup_chk
  import tlb_ring_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_data_side,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [5:0]  rsp_fault,
  input logic [2:0]  rsp_way,
  input logic [2:0]  rsp_index,
  input logic [1:0]  rsp_ring,
  input logic [31:0] rsp_paddr,
  input logic [3:0]  rsp_attr
);

  assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_rsp_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && $stable(rsp_status) && $stable(rsp_paddr) && $stable(rsp_way));

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_MISS) |->
      (rsp_way == '0 && rsp_index == '0 && rsp_ring == '0 && rsp_paddr == '0 && rsp_attr == '0));

  assert_multi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_MULTI) |->
      (rsp_way == '0 && rsp_index == '0 && rsp_ring == '0 && rsp_paddr == '0 && rsp_attr == '0));

  assert_hit_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_HIT) |-> rsp_fault == '0);

  assert_data_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_data_side) |=>
      (rsp_status == ST_HIT || rsp_fault == FC_D_MISS || rsp_fault == FC_D_MULTI));

  assert_instr_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_data_side) |=>
      (rsp_status == ST_HIT || rsp_fault == FC_I_MISS || rsp_fault == FC_I_MULTI));

  assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);

endmodule

bind tlb_ring_lookup tlb_ring_lookup_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_data_side(lk_data_side),
  .rsp_valid   (rsp_valid),
  .rsp_status  (rsp_status),
  .rsp_fault   (rsp_fault),
  .rsp_way     (rsp_way),
  .rsp_index   (rsp_index),
  .rsp_ring    (rsp_ring),
  .rsp_paddr   (rsp_paddr),
  .rsp_attr    (rsp_attr)
);

// File: tb/test_tlb_ring_lookup.sv
module test_tlb_ring_lookup;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        ring_we;
  logic [31:0] ring_wdata;
  logic        ent_we;
  logic [2:0]  ent_way;
  logic [31:0] ent_vaddr;
  logic [31:0] ent_pte;
  logic        lk_valid;
  logic        lk_data_side;
  logic [31:0] lk_vaddr;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [5:0]  rsp_fault;
  logic [2:0]  rsp_way;
  logic [2:0]  rsp_index;
  logic [1:0]  rsp_ring;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_attr;

  tlb_ring_lookup i_tlb_ring_lookup (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ring_we(ring_we), .ring_wdata(ring_wdata),
    .ent_we(ent_we), .ent_way(ent_way), .ent_vaddr(ent_vaddr), .ent_pte(ent_pte),
    .lk_valid(lk_valid), .lk_data_side(lk_data_side), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_fault(rsp_fault),
    .rsp_way(rsp_way), .rsp_index(rsp_index), .rsp_ring(rsp_ring),
    .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  // Behavioural reference state
  logic [31:0] m_tag  [7][8];
  logic [31:0] m_pa   [7][8];
  int          m_asid [7][8];
  int          m_attr [7][8];
  bit          m_lock [7][8];
  logic [31:0] m_ring;
  int          f4;

  logic [52:0] exp_vec;

  function automatic logic [31:0] way_mask(int w);
    if (w < 4) return 32'hFFFFF000;
    if (w == 4) return 32'hFFF00000 << (2 * f4);
    if (w == 5) return 32'hF8000000;
    return 32'hF0000000;
  endfunction

  function automatic int way_idx(int w, logic [31:0] va);
    if (w < 4) return int'((va >> 12) & 32'd3);
    if (w == 4) return int'((va >> (20 + 2 * f4)) & 32'd3);
    if (w == 5) return int'((va >> 27) & 32'd1);
    return int'((va >> 28) & 32'd1);
  endfunction

  task automatic model_reset();
    for (int w = 0; w < 7; w++) begin
      for (int e = 0; e < 8; e++) begin
        m_tag[w][e] = 0; m_pa[w][e] = 0; m_asid[w][e] = 0;
        m_attr[w][e] = 0; m_lock[w][e] = 0;
      end
    end
    m_tag[5][0] = 32'hD0000000; m_pa[5][0] = 0; m_attr[5][0] = 7;
    m_tag[5][1] = 32'hD8000000; m_pa[5][1] = 0; m_attr[5][1] = 3;
    m_tag[6][0] = 32'hE0000000; m_pa[6][0] = 32'hF0000000; m_attr[6][0] = 7;
    m_tag[6][1] = 32'hF0000000; m_pa[6][1] = 32'hF0000000; m_attr[6][1] = 3;
    for (int w = 5; w < 7; w++) begin
      for (int e = 0; e < 2; e++) begin
        m_asid[w][e] = 1; m_lock[w][e] = 1;
      end
    end
    m_ring  = 32'h04030201;
    f4      = 0;
    exp_vec = '0;
  endtask

  function automatic logic [51:0] model_lookup(logic [31:0] va, logic side);
    int nh = 0;
    int hw = 0, hi = 0, hr = 0;
    logic [51:0] r;
    for (int w = 0; w < 7; w++) begin
      int e = way_idx(w, va);
      if (m_tag[w][e] == (va & way_mask(w)) && m_asid[w][e] != 0) begin
        int rg = -1;
        for (int s = 0; s < 4; s++) begin
          if (rg < 0 && int'((m_ring >> (8 * s)) & 32'hFF) == m_asid[w][e]) rg = s;
        end
        if (rg >= 0) begin
          nh++; hw = w; hi = e; hr = rg;
        end
      end
    end
    if (nh == 0) begin
      r = {2'd1, side ? 6'd24 : 6'd16, 44'd0};
    end else if (nh == 1) begin
      r = {2'd0, 6'd0, 3'(hw), 3'(hi), 2'(hr),
           m_pa[hw][hi] | (va & ~way_mask(hw)), 4'(m_attr[hw][hi])};
    end else begin
      r = {2'd2, side ? 6'd25 : 6'd17, 44'd0};
    end
    return r;
  endfunction

  task automatic tick();
    logic [52:0] act;
    @(posedge clk);
    if (lk_valid) exp_vec = {1'b1, model_lookup(lk_vaddr, lk_data_side)};
    else          exp_vec[52] = 1'b0;
    if (ent_we && ent_way < 7) begin
      int w = int'(ent_way);
      int e = way_idx(w, ent_vaddr);
      if (!m_lock[w][e]) begin
        m_tag[w][e]  = ent_vaddr & way_mask(w);
        m_pa[w][e]   = ent_pte & way_mask(w);
        m_attr[w][e] = int'(ent_pte[3:0]);
        m_asid[w][e] = int'((m_ring >> (8 * ent_pte[5:4])) & 32'hFF);
      end
    end
    if (cfg_we)  f4 = int'(cfg_wdata[17:16]);
    if (ring_we) m_ring = {ring_wdata[31:8], 8'h01};
    #1;
    act = {rsp_valid, rsp_status, rsp_fault, rsp_way, rsp_index, rsp_ring, rsp_paddr, rsp_attr};
    n_checks++;
    if (act !== exp_vec) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", cur_req, act, exp_vec);
    end
  endtask

  task automatic lookup(logic [31:0] va, logic side);
    lk_valid = 1'b1; lk_vaddr = va; lk_data_side = side;
    tick();
    lk_valid = 1'b0;
  endtask

  task automatic wr_entry(logic [2:0] w, logic [31:0] va, logic [31:0] pte);
    ent_we = 1'b1; ent_way = w; ent_vaddr = va; ent_pte = pte;
    tick();
    ent_we = 1'b0;
  endtask

  task automatic wr_cfg(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic wr_ring(logic [31:0] v);
    ring_we = 1'b1; ring_wdata = v;
    tick();
    ring_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; ring_we = 0; ring_wdata = 0;
    ent_we = 0; ent_way = 0; ent_vaddr = 0; ent_pte = 0;
    lk_valid = 0; lk_data_side = 0; lk_vaddr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1"; idle(2);

    // Preset fixed ways 5/6
    cur_req = "R2"; lookup(32'hD0001234, 1'b0);
    cur_req = "R5"; lookup(32'hDC000004, 1'b1);
    cur_req = "R2"; lookup(32'hE1234567, 1'b0);
    cur_req = "R14"; lookup(32'hF8000010, 1'b1);

    // Miss on empty refill ways, both sides
    cur_req = "R8"; lookup(32'h00001000, 1'b0);
    cur_req = "R9"; lookup(32'h00001000, 1'b1);

    // Refill-way writes; ring select 3 uses the reset ring word (R1)
    cur_req = "R11"; wr_entry(3'd2, 32'h12345000, 32'hABCDE035);
    cur_req = "R1";  lookup(32'h12345ABC, 1'b0);
    cur_req = "R3";  wr_entry(3'd0, 32'h00007000, 32'h11111000);
    cur_req = "R3";  lookup(32'h00007FFC, 1'b1);
    cur_req = "R3";  lookup(32'h00006FFC, 1'b1);

    // Way 4 under two size settings
    cur_req = "R4"; wr_cfg(32'h00020000);
    cur_req = "R4"; wr_entry(3'd4, 32'h27000000, 32'h55000013);
    cur_req = "R4"; lookup(32'h27ABCDEF, 1'b0);
    cur_req = "R4"; wr_cfg(32'h00000000);
    cur_req = "R4"; lookup(32'h27ABCDEF, 1'b0);
    cur_req = "R4"; wr_cfg(32'h00020000);

    // Way 7 write has no effect
    cur_req = "R11"; wr_entry(3'd7, 32'h00003000, 32'h99999000);
    cur_req = "R11"; lookup(32'h00003000, 1'b0);

    // Multi-hit between way 1 and preset way 5
    cur_req = "R7"; wr_entry(3'd1, 32'hD0000000, 32'h00000002);
    cur_req = "R7"; lookup(32'hD0000ABC, 1'b1);
    cur_req = "R9"; lookup(32'hD0000ABC, 1'b0);

    // Immutable entries ignore writes
    cur_req = "R12"; wr_entry(3'd5, 32'hD8000000, 32'h12345037);
    cur_req = "R12"; lookup(32'hD8000100, 1'b0);
    cur_req = "R12"; wr_entry(3'd6, 32'hF0000000, 32'h00000000);
    cur_req = "R12"; lookup(32'hF0000020, 1'b1);

    // Ring register rewrite with low byte forced
    cur_req = "R10"; wr_ring(32'h0A0B0CFF);
    cur_req = "R10"; lookup(32'h27ABCDEF, 1'b0);
    cur_req = "R10"; lookup(32'h12345ABC, 1'b1);
    cur_req = "R6";  wr_entry(3'd3, 32'h00402000, 32'h77700010);
    cur_req = "R6";  lookup(32'h00402123, 1'b0);
    cur_req = "R10"; lookup(32'hD8000200, 1'b0);

    // Same-cycle write and lookup, back-to-back lookups, idle hold
    cur_req = "R13";
    ent_we = 1'b1; ent_way = 3'd0; ent_vaddr = 32'h00005000; ent_pte = 32'h22222004;
    lk_valid = 1'b1; lk_vaddr = 32'h00005000; lk_data_side = 1'b0;
    tick();
    ent_we = 1'b0;
    lookup(32'h00005010, 1'b0);
    lookup(32'hE0000000, 1'b1);
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule